// File: doc/BRIEF.md
# Test-and-Set Semaphore Unit

This block guards a bank of one-bit semaphores shared by several requesters. A requester asks for either a test-and-set or a clear on one semaphore, selected by a 4-bit index. A test-and-set runs as an indivisible two-cycle sequence. In the first cycle the unit reads the old bit into a result register. In the second cycle it writes 1 back to the same bit. A lock output is held high across both cycles, and no other requester can start an operation while it is high.

A returned result of 0 means the resource was free and the caller now owns it. A result of 1 means it was already taken, and the caller must stay out of the critical section. A clear takes one locked cycle. It writes 0 to the selected bit and is serialized with test-and-set in the same way.

Requests that arrive together are resolved round-robin. Every requester that is not granted sees its ready signal low and keeps its request up until it is accepted.

Top module: `tas_sem_unit`

## Requirements
- R1: After reset all 16 semaphores read as 0, `bus_lock` is 0, `done` is all zero, and no `req_ready` bit is high while no request is valid.
- R2: A test-and-set (`req_op` bit = 0) on a semaphore that is 0 locks for two cycles. In the second locked cycle `done` pulses to the caller with `result` = 0, and the semaphore is 1 afterwards.
- R3: A test-and-set on a semaphore that is 1 returns `result` = 1 in its second locked cycle and leaves the semaphore at 1.
- R4: A test-and-set is accepted on a clock edge where the caller's `req_valid` and `req_ready` are both high. `bus_lock` is then high for exactly the next two cycles and low in the cycle after the `done` pulse.
- R5: While `bus_lock` is high, every `req_ready` bit is 0.
- R6: A clear (`req_op` bit = 1) locks for one cycle. In that cycle `done` pulses to the caller with `result` = 0, and the semaphore is 0 afterwards.
- R7: When the unit is idle, at most one `req_ready` bit is high, and only for a valid requester. The granted requester is the first valid one found searching upward, with wrap-around, from the last granted index. After reset the search starts at requester 0.
- R8: `done` is high for one cycle and only on the owner's bit. A waiting requester is accepted in the same cycle that `bus_lock` drops, so back-to-back test-and-sets start every 3 cycles.
- R9: An operation changes only the semaphore selected by the caller's index field, which is `req_idx[i*4 +: 4]` for requester i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_op | input | N_REQ | Operation per requester: 0 test-and-set, 1 clear |
| req_idx | input | N_REQ*4 | Semaphore index per requester, 4 bits each |
| req_ready | output | N_REQ | Request accepted on this edge when also valid |
| done | output | N_REQ | One-cycle completion pulse to the owner |
| result | output | 1 | Old semaphore value, valid while done is high |
| bus_lock | output | 1 | Shared path is locked by an operation in flight |

## Verification
The bench builds the unit with its default of four requesters and sixteen semaphores. With four requesters, a three-way contention can start from a pointer that is not at requester 0, so the round-robin wrap from requester 3 back to 0 is reached. Sixteen semaphores allow testing the two end indices, 0 and 15, next to middle ones. The bench also checks that an operation on one index leaves its neighbours alone.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TEST = 2'd1,
        ST_SET  = 2'd2,
        ST_CLR  = 2'd3
    } seq_state_e;

    typedef enum logic {
        OP_TAS = 1'b0,
        OP_CLR = 1'b1
    } sem_op_e;

    // First valid index above 'last' (circular) among n requesters, -1 if none.
    function automatic int rr_first(input logic [63:0] vld, input int last, input int n);
        int found;
        found = -1;
        for (int k = 1; k <= n; k++) begin
            if (found < 0 && vld[(last + k) % n]) begin
                found = (last + k) % n;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/sem_rr_arb.sv
module sem_rr_arb #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] vld,
    input  logic         enable,
    output logic [N-1:0] grant,
    output logic [W-1:0] grant_id,
    output logic         any
);
    import sem_pkg::*;

    logic [W-1:0] last_q;
    int           pick;

    always_comb begin
        pick     = rr_first(64'(vld), int'(last_q), N);
        any      = (pick >= 0);
        grant_id = any ? W'(pick) : '0;
        grant    = (enable && any) ? (N'(1) << grant_id) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= W'(N - 1);
        end else if (enable && any) begin
            last_q <= grant_id;
        end
    end
endmodule

// File: rtl/sem_store.sv
module sem_store #(
    parameter int NUM_SEM = 16,
    localparam int IW = $clog2(NUM_SEM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_bit,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_val
);
    logic [NUM_SEM-1:0] bits_q;

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q[s] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(s)) begin
                bits_q[s] <= wr_val;
            end
        end
    end

    assign rd_bit = bits_q[rd_idx];
endmodule

// File: rtl/sem_seq.sv
module sem_seq #(
    parameter int N = 4,
    parameter int IW = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [W-1:0]  acc_id,
    input  logic          acc_op,
    input  logic [IW-1:0] acc_idx,
    input  logic          rd_bit,
    output logic [IW-1:0] cur_idx,
    output logic          wr_en,
    output logic          wr_val,
    output logic          idle,
    output logic          lock,
    output logic [N-1:0]  done,
    output logic          result
);
    import sem_pkg::*;

    seq_state_e    state_q;
    logic [W-1:0]  owner_q;
    logic [IW-1:0] idx_q;
    logic          r_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            idx_q   <= '0;
            r_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    owner_q <= acc_id;
                    idx_q   <= acc_idx;
                    state_q <= (sem_op_e'(acc_op) == OP_CLR) ? ST_CLR : ST_TEST;
                end
                ST_TEST: begin
                    r_q     <= rd_bit;
                    state_q <= ST_SET;
                end
                ST_SET:  state_q <= ST_IDLE;
                ST_CLR:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle    = (state_q == ST_IDLE);
        lock    = !idle;
        cur_idx = idx_q;
        wr_en   = (state_q == ST_SET) || (state_q == ST_CLR);
        wr_val  = (state_q == ST_SET);
        done    = wr_en ? (N'(1) << owner_q) : '0;
        result  = (state_q == ST_SET) ? r_q : 1'b0;
    end
endmodule

// File: rtl/tas_sem_unit.sv
module tas_sem_unit #(
    parameter int N_REQ = 4,
    parameter int NUM_SEM = 16,
    localparam int IW = $clog2(NUM_SEM),
    localparam int W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_REQ-1:0]  req_valid,
    input  logic [N_REQ-1:0]  req_op,
    input  logic [N_REQ*IW-1:0] req_idx,
    output logic [N_REQ-1:0]  req_ready,
    output logic [N_REQ-1:0]  done,
    output logic              result,
    output logic              bus_lock
);
    logic          idle, any, rd_bit, wr_en, wr_val;
    logic [W-1:0]  gid;
    logic [IW-1:0] cur_idx, sel_idx;
    logic          sel_op;

    sem_rr_arb #(.N(N_REQ)) u_arb (
        .clk(clk), .rst(rst), .vld(req_valid), .enable(idle),
        .grant(req_ready), .grant_id(gid), .any(any)
    );

    assign sel_idx = req_idx[gid*IW +: IW];
    assign sel_op  = req_op[gid];

    sem_seq #(.N(N_REQ), .IW(IW)) u_seq (
        .clk(clk), .rst(rst), .accept(idle && any), .acc_id(gid),
        .acc_op(sel_op), .acc_idx(sel_idx), .rd_bit(rd_bit),
        .cur_idx(cur_idx), .wr_en(wr_en), .wr_val(wr_val), .idle(idle),
        .lock(bus_lock), .done(done), .result(result)
    );

    sem_store #(.NUM_SEM(NUM_SEM)) u_store (
        .clk(clk), .rst(rst), .rd_idx(cur_idx), .rd_bit(rd_bit),
        .wr_en(wr_en), .wr_idx(cur_idx), .wr_val(wr_val)
    );
endmodule

// File: rtl/tas_sem_unit_checker.sv
module tas_sem_unit_checker #(
    parameter int N_REQ = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_REQ-1:0] req_valid,
    input logic [N_REQ-1:0] req_ready,
    input logic [N_REQ-1:0] done,
    input logic             bus_lock
);
    p_lock_blocks_ready_r5: assert property (@(posedge clk) disable iff (rst)
        bus_lock |-> (req_ready == '0));

    p_ready_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    p_ready_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (req_ready & ~req_valid) == '0);

    p_accept_locks_r4: assert property (@(posedge clk) disable iff (rst)
        (|(req_valid & req_ready)) |=> bus_lock);

    p_done_releases_r4: assert property (@(posedge clk) disable iff (rst)
        (|done) |=> !bus_lock);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));

    p_done_under_lock_r6: assert property (@(posedge clk) disable iff (rst)
        (|done) |-> bus_lock);
endmodule

bind tas_sem_unit tas_sem_unit_checker #(.N_REQ(N_REQ)) u_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .bus_lock(bus_lock)
);

// File: tb/tas_sem_unit_bench.sv
module tas_sem_unit_bench;
    localparam int PERIOD = 10;
    localparam int NR = 4;
    localparam int NV = 13;
    // entry: {requester[1:0], op, idx[3:0], expected result}
    localparam logic [7:0] VEC [NV] = '{
        {2'd0, 1'b0, 4'd3,  1'b0}, {2'd1, 1'b0, 4'd3,  1'b1},
        {2'd2, 1'b0, 4'd4,  1'b0}, {2'd3, 1'b1, 4'd3,  1'b0},
        {2'd0, 1'b0, 4'd3,  1'b0}, {2'd1, 1'b0, 4'd4,  1'b1},
        {2'd1, 1'b1, 4'd4,  1'b0}, {2'd2, 1'b0, 4'd15, 1'b0},
        {2'd3, 1'b0, 4'd0,  1'b0}, {2'd2, 1'b0, 4'd4,  1'b0},
        {2'd3, 1'b0, 4'd15, 1'b1}, {2'd0, 1'b1, 4'd9,  1'b0},
        {2'd0, 1'b0, 4'd9,  1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] req_valid = '0;
    logic [NR-1:0] req_op = '0;
    logic [NR*4-1:0] req_idx = '0;
    logic [NR-1:0] req_ready, done;
    logic          result, bus_lock;
    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    tas_sem_unit #(.N_REQ(NR), .NUM_SEM(16)) u_tas_sem_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_ready(req_ready), .done(done),
        .result(result), .bus_lock(bus_lock)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Runs one operation from an idle unit; caller is at a negedge.
    task automatic run_op(input int r, input bit op, input int idx, input bit exp, input string tag);
        req_valid[r] = 1'b1;
        req_op[r] = op;
        req_idx[r*4 +: 4] = 4'(idx);
        #1;
        chk(req_ready == 4'(1 << r), "R7 ready to sole requester", int'(req_ready), 1 << r);
        @(posedge clk); #1;
        req_valid[r] = 1'b0;
        @(negedge clk);
        chk(bus_lock == 1'b1, "R4 lock in first cycle", int'(bus_lock), 1);
        chk(req_ready == '0, "R5 ready low under lock", int'(req_ready), 0);
        if (!op) begin
            chk(done == '0, "R4 no done in test cycle", int'(done), 0);
            @(negedge clk);
            chk(bus_lock == 1'b1, "R4 lock in second cycle", int'(bus_lock), 1);
        end
        chk(done == 4'(1 << r), {tag, " done to owner (R8)"}, int'(done), 1 << r);
        chk(result == exp, {tag, " result"}, int'(result), int'(exp));
        @(negedge clk);
        chk(bus_lock == 1'b0, "R4 lock released", int'(bus_lock), 0);
        chk(done == '0, "R8 done one cycle", int'(done), 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int order [3];
        int when [3];
        int k;
        int t;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(bus_lock == 1'b0, "R1 lock after reset", int'(bus_lock), 0);
        chk(done == '0, "R1 done after reset", int'(done), 0);
        chk(req_ready == '0, "R1 no ready without request", int'(req_ready), 0);

        // Table walk: R2 (free), R3 (taken), R6 (clear), R9 (other indices untouched)
        for (int i = 0; i < NV; i++) begin
            run_op(int'(VEC[i][7:6]), VEC[i][5], int'(VEC[i][4:1]), VEC[i][0],
                   VEC[i][5] ? "R6 clear" : (VEC[i][0] ? "R3 taken" : "R2 free/R9"));
        end

        // Move pointer to requester 1, then contention from 0, 2, 3 (R7 wrap, R8 spacing)
        run_op(1, 1'b0, 7, 1'b0, "R2 free");
        req_op = '0;
        req_idx = {4'd12, 4'd11, 4'd0, 4'd10};
        req_valid = 4'b1101;
        k = 0;
        t = 0;
        for (int c = 0; c < 12; c++) begin
            #1;
            if (bus_lock) chk(req_ready == '0, "R5 ready low during contention", int'(req_ready), 0);
            if (|done) chk(result == 1'b0, "R2 contention result", int'(result), 0);
            if (|req_ready && k < 3) begin
                for (int j = 0; j < NR; j++) if (req_ready[j]) order[k] = j;
                when[k] = t;
                @(posedge clk); #1;
                req_valid[order[k]] = 1'b0;
                k++;
            end
            @(negedge clk);
            t++;
        end
        chk(k == 3, "R7 all contenders granted", k, 3);
        chk(order[0] == 2, "R7 first grant after pointer", order[0], 2);
        chk(order[1] == 3, "R7 second grant", order[1], 3);
        chk(order[2] == 0, "R7 wrap-around grant", order[2], 0);
        chk(when[1] - when[0] == 3, "R8 back-to-back spacing", when[1] - when[0], 3);
        chk(when[2] - when[1] == 3, "R8 back-to-back spacing", when[2] - when[1], 3);

        // R9: neighbours of 10..12 untouched by the contention
        run_op(0, 1'b0, 13, 1'b0, "R9 neighbour free");
        run_op(3, 1'b0, 11, 1'b1, "R3 contention set");

        // R1: reset clears semaphores that were set
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        run_op(0, 1'b0, 15, 1'b0, "R1 cleared by reset");
        run_op(1, 1'b0, 3, 1'b0, "R1 cleared by reset");

        finish_run();
    end
endmodule